// File: doc/BRIEF.md
# Branch Resolution Stall Controller

This block decides how long each branch holds the branch unit of a simple in-order pipeline. A branch is offered with its class, a flag saying whether it was first decoded from the front prefetch-buffer slot or from the decode stage, and flags for address and condition dependencies. It also receives the number of instructions between the branch and the instruction producing its dependency, and the resolved outcome. From these it computes a cycle cost of one to three. It holds a busy signal for the cost minus one cycles, and it raises a one-cycle flush pulse when a predicted branch turns out to be wrong.

A branch is accepted on a rising clock edge where `br_valid` is high and `busy` is low. All results appear in the cycle that follows that edge. Combinations that cannot occur in a legal instruction stream are reported on `illegal` and charged one cycle. Fetch, target calculation and the predictor itself belong to other blocks.

Top module: `brstall_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `flush` and `illegal` are low and `stall_cycles` is 0.
- R2: A legal known-not-taken branch (`br_class` = 0) costs 1 cycle whatever its outcome and never flushes.
- R3: A known-taken branch (`br_class` = 1) without an address dependency, or whose address producer is two or more instructions away (`dep_gap` >= 2), costs 1 cycle when `from_pfb` = 1 and 2 cycles when `from_pfb` = 0.
- R4: A known-taken branch with an address dependency costs 3 cycles at `dep_gap` = 0 and 2 cycles at `dep_gap` = 1.
- R5: A correctly predicted branch costs 1 cycle for predicted-not-taken (`br_class` = 2, `taken` = 0). For predicted-taken (`br_class` = 3, `taken` = 1) it costs 1 cycle when `from_pfb` = 1 and 2 cycles when `from_pfb` = 0.
- R6: A mispredicted branch (class 2 with `taken` = 1, or class 3 with `taken` = 0) costs 3 cycles at `dep_gap` = 0, 2 cycles at `dep_gap` = 1 and 1 cycle at `dep_gap` >= 2.
- R7: `flush` is high for exactly the one cycle after a mispredicted branch is accepted, and it is low after every other acceptance.
- R8: After an acceptance, `busy` stays high for exactly `stall_cycles` - 1 cycles. A branch offered while `busy` is high is ignored and leaves every output unchanged.
- R9: The following combinations are illegal: class 0 with any dependency flag, class 1 with `cond_dep`, and class 2 or 3 without `cond_dep` or with `addr_dep`. An illegal branch sets `illegal`, costs 1 cycle and does not flush. A legal branch clears `illegal`.
- R10: `stall_cycles` and `illegal` hold their values until the next accepted branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A branch is offered this cycle |
| br_class | input | 2 | 0 known not taken, 1 known taken, 2 predicted not taken, 3 predicted taken |
| from_pfb | input | 1 | 1: first decoded from the front prefetch slot, 0: from the decode stage |
| addr_dep | input | 1 | Target address depends on an earlier instruction |
| cond_dep | input | 1 | Condition depends on an earlier instruction |
| dep_gap | input | GAP_W | Instructions between the branch and its dependency producer |
| taken | input | 1 | Resolved outcome of the branch |
| stall_cycles | output | 2 | Cycle cost of the last accepted branch |
| busy | output | 1 | Branch unit occupied; no new branch accepted |
| flush | output | 1 | One-cycle misprediction flush |
| illegal | output | 1 | Last accepted branch had an impossible combination |

## Verification
Every result is registered once. The cost, the flush pulse and the error flag of a branch accepted at edge k are due in the cycle after edge k. The bench drives inputs on the falling edge and samples on the next falling edge. It then counts the falling edges on which `busy` stays high and compares that count with the cost minus one. During that window it sometimes offers a second branch and checks that the outputs have not moved. It also checks that `flush` has dropped one cycle after its pulse.

// File: rtl/brstall_pkg.sv
// Package brstall_pkg
// Shared types and derived widths for the branch stall controller.
// Assumes the largest branch cost is three cycles.
package brstall_pkg;
    localparam int MAX_COST = 3;
    localparam int COST_W   = $clog2(MAX_COST + 1);

    typedef enum logic [1:0] {
        BR_KNOWN_NT = 2'd0,
        BR_KNOWN_T  = 2'd1,
        BR_PRED_NT  = 2'd2,
        BR_PRED_T   = 2'd3
    } br_class_e;
endpackage

// File: rtl/brstall_cost.sv
// Module brstall_cost
// Purely combinational cost evaluation of one branch: cycle cost, misprediction
// and illegal-combination detection. Assumes dep_gap counts the instructions
// between the branch and its producer; two or more is treated as no dependency.
module brstall_cost
    import brstall_pkg::*;
#(
    parameter int GAP_W = 3
) (
    input  br_class_e          cls,
    input  logic               from_pfb,
    input  logic               addr_dep,
    input  logic               cond_dep,
    input  logic [GAP_W-1:0]   gap,
    input  logic               taken,
    output logic [COST_W-1:0]  cost,
    output logic               mispredict,
    output logic               illegal
);
    logic [COST_W-1:0] slot_cost;
    logic [COST_W-1:0] near_cost;
    logic              near;

    // Cost terms from the decode slot and from the producer distance
    always_comb begin
        slot_cost = from_pfb ? COST_W'(1) : COST_W'(2);
        near      = (gap < GAP_W'(2));
        near_cost = (gap == '0) ? COST_W'(3) : COST_W'(2);
    end

    // Class-dependent cost, misprediction and legality
    always_comb begin
        cost       = COST_W'(1);
        mispredict = 1'b0;
        illegal    = 1'b0;
        unique case (cls)
            BR_KNOWN_NT: begin
                illegal = addr_dep | cond_dep;
            end
            BR_KNOWN_T: begin
                illegal = cond_dep;
                cost    = (addr_dep && near) ? near_cost : slot_cost;
            end
            BR_PRED_NT: begin
                illegal    = ~cond_dep | addr_dep;
                mispredict = taken;
                cost       = taken ? (near ? near_cost : COST_W'(1)) : COST_W'(1);
            end
            BR_PRED_T: begin
                illegal    = ~cond_dep | addr_dep;
                mispredict = ~taken;
                cost       = ~taken ? (near ? near_cost : COST_W'(1)) : slot_cost;
            end
            default: ;
        endcase
        if (illegal) begin
            cost       = COST_W'(1);
            mispredict = 1'b0;
        end
    end
endmodule

// File: rtl/brstall_timer.sv
// Module brstall_timer
// Countdown that keeps busy high for (cost - 1) cycles after a load.
// Assumes load is only raised while busy is low.
module brstall_timer
    import brstall_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [COST_W-1:0] cost,
    output logic              busy
);
    logic [COST_W-1:0] remaining;

    // Load cost-1 on acceptance, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= cost - COST_W'(1);
        else if (remaining != '0)
            remaining <= remaining - COST_W'(1);
    end

    assign busy = (remaining != '0);

    // R8: a countdown never starts from a cost of zero
    a_r8_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cost != '0);
    // R8: a load never lands on a running count
    a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
endmodule

// File: rtl/brstall_ctrl.sv
// Module brstall_ctrl (top)
// Accepts one branch when idle, registers its cycle cost, flush pulse and
// illegal flag, and holds busy for the cost minus one cycles.
// Assumes the outcome is valid in the same cycle as br_valid.
module brstall_ctrl
    import brstall_pkg::*;
#(
    parameter int GAP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [1:0]        br_class,
    input  logic              from_pfb,
    input  logic              addr_dep,
    input  logic              cond_dep,
    input  logic [GAP_W-1:0]  dep_gap,
    input  logic              taken,
    output logic [1:0]        stall_cycles,
    output logic              busy,
    output logic              flush,
    output logic              illegal
);
    logic [COST_W-1:0] cost_c;
    logic              mispredict_c;
    logic              illegal_c;
    logic              accept;
    logic [COST_W-1:0] stall_q;
    logic              flush_q;
    logic              illegal_q;

    assign accept = br_valid & ~busy;

    brstall_cost #(.GAP_W(GAP_W)) u_cost (
        .cls        (br_class_e'(br_class)),
        .from_pfb   (from_pfb),
        .addr_dep   (addr_dep),
        .cond_dep   (cond_dep),
        .gap        (dep_gap),
        .taken      (taken),
        .cost       (cost_c),
        .mispredict (mispredict_c),
        .illegal    (illegal_c)
    );

    brstall_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .cost  (cost_c),
        .busy  (busy)
    );

    // Capture the result of an accepted branch; flush lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q   <= '0;
            flush_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            flush_q <= accept & mispredict_c;
            if (accept) begin
                stall_q   <= cost_c;
                illegal_q <= illegal_c;
            end
        end
    end

    assign stall_cycles = 2'(stall_q);
    assign flush        = flush_q;
    assign illegal      = illegal_q;

    // R7: a flush only follows an acceptance
    a_r7_flush_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(rst_n) && $past(br_valid) && !$past(busy));
    // R9: an illegal branch is charged one cycle and never flushes
    a_r9_illegal_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> stall_cycles == 2'd1 && !flush && !busy);
    // R2: known-not-taken costs one cycle
    a_r2_knt_one: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(accept) && $past(br_class) == 2'd0 |-> stall_cycles == 2'd1 && !flush);
    // R8, R10: outputs hold while busy
    a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(stall_cycles) && $stable(illegal));
    // R8: busy only rises for a cost of two or more
    a_r8_busy_cost: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> stall_cycles >= 2'd2);
endmodule

// File: tb/brstall_ctrl_test.sv
module brstall_ctrl_test;
    localparam int GAP_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [1:0]       br_class = '0;
    logic             from_pfb = 1'b0;
    logic             addr_dep = 1'b0;
    logic             cond_dep = 1'b0;
    logic [GAP_W-1:0] dep_gap = '0;
    logic             taken = 1'b0;
    logic [1:0]       stall_cycles;
    logic             busy;
    logic             flush;
    logic             illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    brstall_ctrl #(.GAP_W(GAP_W)) uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_class(br_class),
        .from_pfb(from_pfb), .addr_dep(addr_dep), .cond_dep(cond_dep),
        .dep_gap(dep_gap), .taken(taken), .stall_cycles(stall_cycles),
        .busy(busy), .flush(flush), .illegal(illegal)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ref_illegal(int c, bit a, bit d);
        case (c)
            0: return a | d;
            1: return d;
            default: return !d | a;
        endcase
    endfunction

    function automatic bit ref_mis(int c, bit a, bit d, bit t);
        if (ref_illegal(c, a, d)) return 0;
        if (c == 2) return t;
        if (c == 3) return !t;
        return 0;
    endfunction

    function automatic int ref_cost(int c, bit p, bit a, bit d, int g, bit t);
        int slot = p ? 1 : 2;
        int nearc = (g == 0) ? 3 : (g == 1) ? 2 : 1;
        if (ref_illegal(c, a, d)) return 1;
        if (c == 0) return 1;
        if (c == 1) return (a && g < 2) ? nearc : slot;
        if (ref_mis(c, a, d, t)) return nearc;
        return (c == 2) ? 1 : slot;
    endfunction

    // Issue one branch from idle and check all results; optionally poke while busy
    task automatic run_branch(input string req, input int c, input bit p, input bit a,
                              input bit d, input int g, input bit t, input bit poke);
        int ec = ref_cost(c, p, a, d, g, t);
        bit em = ref_mis(c, a, d, t);
        bit ei = ref_illegal(c, a, d);
        int cnt = 0;
        br_class = 2'(c); from_pfb = p; addr_dep = a; cond_dep = d;
        dep_gap = GAP_W'(g); taken = t; br_valid = 1'b1;
        @(negedge clk);
        br_valid = 1'b0;
        check({req, " cost"}, stall_cycles, ec);
        check("R7 flush", flush, em);
        check("R9 illegal", illegal, ei);
        check("R8 busy", busy, ec > 1);
        while (busy && cnt < 8) begin
            if (poke) begin
                br_class = 2'd3; cond_dep = 1'b1; addr_dep = 1'b0;
                dep_gap = '0; taken = 1'b0; br_valid = 1'b1;
            end
            @(negedge clk);
            br_valid = 1'b0;
            cnt++;
            check("R7 flush drop", flush, 0);
            if (poke) begin
                check("R8 ignored cost", stall_cycles, ec);
                check("R10 illegal held", illegal, ei);
            end
        end
        check("R8 busy length", cnt, ec - 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 flush", flush, 0);
        check("R1 illegal", illegal, 0);
        check("R1 stall", stall_cycles, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corner cases
        run_branch("R2", 0, 0, 0, 0, 0, 1, 0);
        run_branch("R3", 1, 1, 0, 0, 0, 1, 0);
        run_branch("R3", 1, 0, 0, 0, 0, 1, 1);
        run_branch("R3", 1, 1, 1, 0, 2, 1, 0);
        run_branch("R4", 1, 1, 1, 0, 0, 1, 1);
        run_branch("R4", 1, 1, 1, 0, 1, 1, 0);
        run_branch("R5", 2, 0, 0, 1, 0, 0, 0);
        run_branch("R5", 3, 1, 0, 1, 0, 1, 0);
        run_branch("R5", 3, 0, 0, 1, 0, 1, 1);
        run_branch("R6", 2, 1, 0, 1, 0, 1, 1);
        run_branch("R6", 3, 1, 0, 1, 1, 0, 0);
        run_branch("R6", 3, 0, 0, 1, 5, 0, 0);
        run_branch("R9", 0, 1, 1, 0, 0, 1, 0);
        run_branch("R9", 1, 0, 0, 1, 0, 1, 0);
        run_branch("R9", 2, 1, 0, 0, 0, 1, 0);
        run_branch("R9", 3, 1, 1, 1, 0, 0, 0);
        // back-to-back one-cycle mispredicts: flush on consecutive acceptances
        run_branch("R6", 2, 1, 0, 1, 3, 1, 0);
        run_branch("R7", 3, 1, 0, 1, 4, 0, 0);
        // constrained random
        for (int i = 0; i < 400; i++) begin
            int c = int'($urandom_range(0, 3));
            bit legal = ($urandom_range(0, 7) != 0);
            bit a = 0;
            bit d = 0;
            if (legal) begin
                if (c == 1) a = 1'($urandom_range(0, 1));
                if (c >= 2) d = 1'b1;
            end else begin
                a = 1'($urandom_range(0, 1));
                d = 1'($urandom_range(0, 1));
            end
            run_branch("R10 rnd", c, 1'($urandom_range(0, 1)), a, d,
                       int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule